// File: doc/BRIEF.md
# Serial Mode-Register Port

This block gives a host a three-pin path into four configuration registers of an audio converter: a shift clock, a data line and a latch line. The host shifts a 16-bit word most significant bit first while holding the latch high, then pulls the latch low to commit the word. Two address bits inside the word pick one of four 9-bit registers. The register fields leave the block as parallel outputs: per-channel attenuation, soft mute, de-emphasis, output enable, zero-detect enable, input format and output routing.

All three serial pins run through two-stage synchronizers into the system clock domain. Edges are detected there, so the host's shift clock never clocks any flop. Commits are refused for a fixed number of system clocks after power-on reset. A separate active-low reset pin disables the port while it is low.

Top module: `ctl_port_top`

## Requirements
- R1: After power-on reset the outputs are: attenuation 255 on both channels, both load flags 0, mute 0, de-emphasis 0, output enable 0, zero-detect enable 0, I2S select 0, word-clock polarity 0, 18-bit flag 0, shared attenuation 0, and routing code 4'h9 (stereo).
- R2: A data bit is captured on each synchronized rising edge of `ctl_clk`, first bit = word bit 15. A synchronized falling edge of `ctl_latch` commits the word to the register chosen by word bits 10:9. The other three registers are left unchanged.
- R3: Register 0 drives `atten_l` from bits 7:0 and `load_l` from bit 8. Register 1 drives `atten_r` and `load_r` from the same bit positions.
- R4: Register 2 drives `mute` from bit 0, `deemph` from bits 2:1 (0 off, 1 48 kHz, 2 44.1 kHz, 3 32 kHz), `out_en` from bit 3 and `zero_det_en` from bit 4.
- R5: Register 3 drives `i2s_sel` from bit 0, `lr_pol` from bit 1, `word18` from bit 2, `atten_shared` from bit 3 and `route_mode` from bits 7:4.
- R6: For LOCK_CYCLES (1024) system clocks after `rst_n` is released, latch commits are ignored. Bits shifted during that window are kept, and a latch fall after the window commits them.
- R7: While `ext_rst_n` is low, clock and latch activity is ignored, a partly shifted word is discarded, and the registers keep their values.
- R8: A committed word with any of bits 15:11 non-zero is ignored.
- R9: A latch fall after fewer than 16 shifted bits is ignored. After more than 16 bits, the last 16 shifted bits are committed.
- R10: If a shift-clock rising edge and a latch falling edge are detected in the same system clock, the word shifted before that cycle is committed and the simultaneous bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | Port disable, active low, asynchronous to clk |
| ctl_clk | input | 1 | Serial shift clock |
| ctl_data | input | 1 | Serial data, MSB first |
| ctl_latch | input | 1 | Commit strobe, falling edge commits |
| atten_l | output | 8 | Left attenuation step |
| load_l | output | 1 | Left load flag |
| atten_r | output | 8 | Right attenuation step |
| load_r | output | 1 | Right load flag |
| mute | output | 1 | Soft mute |
| deemph | output | 2 | De-emphasis selection |
| out_en | output | 1 | Output-enable field |
| zero_det_en | output | 1 | Zero-detect enable |
| i2s_sel | output | 1 | I2S input format select |
| lr_pol | output | 1 | Word-clock polarity |
| word18 | output | 1 | 18-bit word length |
| atten_shared | output | 1 | Left attenuation applies to both channels |
| route_mode | output | 4 | Output routing code |

## Verification
Two cases can land in the same system clock: a shift-clock rising edge and a latch falling edge. The bench provokes this by raising `ctl_clk` and dropping `ctl_latch` on the same system-clock edge, right after a full 16-bit word. It then judges the result from `atten_l` and `load_l`. The committed word must be the one shifted before that cycle (0x00C3). A design that lets the extra bit in would instead show 0x87 with the load flag set. A second overlap is a latch fall during the lockout window on bits that are already shifted; it is judged by whether a later latch still commits those bits.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
    localparam int WORD_W       = 16;
    localparam int ADDR_LSB     = 9;
    localparam int ADDR_W       = 2;
    localparam int NUM_REGS     = 1 << ADDR_W;
    localparam int DATA_W       = ADDR_LSB;
    localparam int RSVD_LSB     = ADDR_LSB + ADDR_W;
    localparam int ATT_W        = 8;
    localparam int ROUTE_W      = 4;
    localparam logic [ROUTE_W-1:0] ROUTE_STEREO = 4'h9;

    typedef logic [DATA_W-1:0] reg_word_t;

    function automatic reg_word_t reg_default(input int idx);
        reg_word_t v;
        case (idx)
            0, 1:    v = reg_word_t'({ATT_W{1'b1}});
            3:       v = reg_word_t'({ROUTE_STEREO, 4'h0});
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cp_lockout.sv
module cp_lockout #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int LCW = $clog2(LOCK_CYCLES + 1);
    localparam logic [LCW-1:0] LIMIT = LCW'(LOCK_CYCLES);

    logic [LCW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/cp_shifter.sv
module cp_shifter #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sck,
    input  logic              sdi,
    input  logic              lat,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              commit_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic              sck_prev;
        logic              lat_prev;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d     = st_q;
        rise     = sck && !st_q.sck_prev;
        fall     = !lat && st_q.lat_prev;
        commit_o = en && fall && (st_q.cnt == FULL);
        st_d.sck_prev = sck;
        st_d.lat_prev = lat;
        if (!en) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (fall) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], sdi};
            if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck_prev <= 1'b0;
            st_q.lat_prev <= 1'b1;
            st_q.sh       <= '0;
            st_q.cnt      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.sh;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/cp_regbank.sv
module cp_regbank
    import ctl_port_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [WORD_W-1:0]                word,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;
    logic [ADDR_W-1:0] addr;
    logic              rsvd_ok;

    always_comb begin
        addr    = word[ADDR_LSB +: ADDR_W];
        rsvd_ok = (word[WORD_W-1:RSVD_LSB] == '0);
        regs_d  = regs_q;
        for (int g = 0; g < NUM_REGS; g++) begin
            if (wr_en && rsvd_ok && (addr == ADDR_W'(g))) begin
                regs_d[g] = word[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_REGS; g++) begin
                regs_q[g] <= reg_default(g);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/ctl_port_top.sv
module ctl_port_top
    import ctl_port_pkg::*;
#(
    parameter int LOCK_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_rst_n,
    input  logic               ctl_clk,
    input  logic               ctl_data,
    input  logic               ctl_latch,
    output logic [ATT_W-1:0]   atten_l,
    output logic               load_l,
    output logic [ATT_W-1:0]   atten_r,
    output logic               load_r,
    output logic               mute,
    output logic [1:0]         deemph,
    output logic               out_en,
    output logic               zero_det_en,
    output logic               i2s_sel,
    output logic               lr_pol,
    output logic               word18,
    output logic               atten_shared,
    output logic [ROUTE_W-1:0] route_mode
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [3:0]                      pins_s;
    logic                            port_en;
    logic                            lock_done;
    logic                            commit;
    logic                            wr_go;
    logic [WORD_W-1:0]               wr_word;
    logic [CNT_W-1:0]                bit_cnt;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            unused_bits;

    cp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ext_rst_n, ctl_latch, ctl_data, ctl_clk}),
        .q(pins_s)
    );

    assign port_en = pins_s[3];

    cp_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .done_o(lock_done)
    );

    cp_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .en(port_en),
        .sck(pins_s[0]), .sdi(pins_s[1]), .lat(pins_s[2]),
        .word_o(wr_word), .cnt_o(bit_cnt), .commit_o(commit)
    );

    assign wr_go = commit && lock_done;

    cp_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .word(wr_word), .regs_o(regs)
    );

    assign atten_l      = regs[0][ATT_W-1:0];
    assign load_l       = regs[0][ATT_W];
    assign atten_r      = regs[1][ATT_W-1:0];
    assign load_r       = regs[1][ATT_W];
    assign mute         = regs[2][0];
    assign deemph       = regs[2][2:1];
    assign out_en       = regs[2][3];
    assign zero_det_en  = regs[2][4];
    assign i2s_sel      = regs[3][0];
    assign lr_pol       = regs[3][1];
    assign word18       = regs[3][2];
    assign atten_shared = regs[3][3];
    assign route_mode   = regs[3][7:4];
    assign unused_bits  = ^{regs[2][DATA_W-1:5], regs[3][DATA_W-1]};
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk
    import ctl_port_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_go,
    input logic                            lock_done,
    input logic                            port_en,
    input logic [CNT_W-1:0]                bit_cnt,
    input logic [WORD_W-1:0]               wr_word,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(regs)); // R2

    AST_ADDR_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_word[ADDR_LSB +: ADDR_W] == 2'd2)
        |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[3]))); // R2

    AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_done |=> $stable(regs)); // R6

    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_done |=> lock_done); // R6

    AST_PORT_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> $stable(regs)); // R7

    AST_RSVD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_word[WORD_W-1:RSVD_LSB] != '0) |=> $stable(regs)); // R8

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_W)); // R9
endmodule

bind ctl_port_top ctl_port_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .lock_done(lock_done),
    .port_en(port_en), .bit_cnt(bit_cnt), .wr_word(wr_word), .regs(regs)
);

// File: tb/tb_ctl_port_top.sv
module tb_ctl_port_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic clk, rst_n, ext_rst_n, ctl_clk, ctl_data, ctl_latch;
    logic [7:0] atten_l, atten_r;
    logic load_l, load_r, mute, out_en, zero_det_en;
    logic i2s_sel, lr_pol, word18, atten_shared;
    logic [1:0] deemph;
    logic [3:0] route_mode;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    ctl_port_top dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .ctl_clk(ctl_clk), .ctl_data(ctl_data), .ctl_latch(ctl_latch),
        .atten_l(atten_l), .load_l(load_l), .atten_r(atten_r), .load_r(load_r),
        .mute(mute), .deemph(deemph), .out_en(out_en), .zero_det_en(zero_det_en),
        .i2s_sel(i2s_sel), .lr_pol(lr_pol), .word18(word18),
        .atten_shared(atten_shared), .route_mode(route_mode)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ctl_data = v[i];
            tick(HALF);
            ctl_clk = 1;
            tick(HALF);
            ctl_clk = 0;
        end
    endtask

    task automatic latch_pulse;
        tick(HALF);
        ctl_latch = 0;
        tick(HALF);
        ctl_latch = 1;
        tick(8);
    endtask

    task automatic write_word(input logic [15:0] w);
        shift_bits(32'(w), 16);
        latch_pulse();
    endtask

    task automatic t_reset;
        chk("R1 atten_l", 32'(atten_l), 32'hFF);
        chk("R1 atten_r", 32'(atten_r), 32'hFF);
        chk("R1 loads", 32'({load_l, load_r}), 32'h0);
        chk("R1 reg2 fields", 32'({mute, deemph, out_en, zero_det_en}), 32'h0);
        chk("R1 format fields", 32'({i2s_sel, lr_pol, word18, atten_shared}), 32'h0);
        chk("R1 route", 32'(route_mode), 32'h9);
    endtask

    task automatic t_lockout;
        write_word(16'h0401);
        chk("R6 write in lockout ignored", 32'(mute), 32'h0);
        shift_bits(32'h0402, 16);
        tick(1100);
        latch_pulse();
        chk("R6 bits kept across lockout", 32'(deemph), 32'h1);
        chk("R6 mute from same word", 32'(mute), 32'h0);
    endtask

    task automatic t_reg01;
        write_word(16'h015A);
        chk("R3 atten_l", 32'(atten_l), 32'h5A);
        chk("R3 load_l", 32'(load_l), 32'h1);
        write_word(16'h0233);
        chk("R3 atten_r", 32'(atten_r), 32'h33);
        chk("R3 load_r", 32'(load_r), 32'h0);
        chk("R2 other register untouched", 32'(atten_l), 32'h5A);
    endtask

    task automatic t_reg2;
        write_word(16'h041D);
        chk("R4 mute", 32'(mute), 32'h1);
        chk("R4 deemph", 32'(deemph), 32'h2);
        chk("R4 out_en", 32'(out_en), 32'h1);
        chk("R4 zero_det_en", 32'(zero_det_en), 32'h1);
        chk("R2 route untouched", 32'(route_mode), 32'h9);
    endtask

    task automatic t_reg3;
        write_word(16'h066D);
        chk("R5 i2s/pol/w18/shared", 32'({i2s_sel, lr_pol, word18, atten_shared}), 32'b1011);
        chk("R5 route", 32'(route_mode), 32'h6);
        write_word(16'h0692);
        chk("R5 second pattern", 32'({i2s_sel, lr_pol, word18, atten_shared}), 32'b0100);
        chk("R5 route back", 32'(route_mode), 32'h9);
        chk("R2 reg2 untouched", 32'(mute), 32'h1);
    endtask

    task automatic t_reserved;
        write_word(16'h0811);
        chk("R8 bit11 set ignored", 32'(atten_l), 32'h5A);
        write_word(16'h8011);
        chk("R8 bit15 set ignored", 32'(atten_l), 32'h5A);
    endtask

    task automatic t_length;
        shift_bits(32'h0022, 15);
        latch_pulse();
        chk("R9 short word ignored", 32'(atten_l), 32'h5A);
        shift_bits(32'hF0044, 20);
        latch_pulse();
        chk("R9 long word keeps last 16", 32'(atten_l), 32'h44);
        chk("R9 long word load flag", 32'(load_l), 32'h0);
    endtask

    task automatic t_ext_rst;
        ext_rst_n = 0;
        tick(4);
        write_word(16'h00AA);
        chk("R7 write while disabled ignored", 32'(atten_l), 32'h44);
        ext_rst_n = 1;
        tick(4);
        shift_bits(32'h00, 8);
        ext_rst_n = 0;
        tick(4);
        ext_rst_n = 1;
        tick(4);
        shift_bits(32'h77, 8);
        latch_pulse();
        chk("R7 partial word discarded", 32'(atten_l), 32'h44);
        write_word(16'h0011);
        chk("R7 port works again", 32'(atten_l), 32'h11);
    endtask

    task automatic t_same_cycle;
        shift_bits(32'h00C3, 16);
        ctl_data = 1;
        tick(HALF);
        ctl_clk = 1;
        ctl_latch = 0;
        tick(HALF);
        ctl_clk = 0;
        ctl_latch = 1;
        tick(8);
        chk("R10 prior word committed", 32'(atten_l), 32'hC3);
        chk("R10 extra bit dropped", 32'(load_l), 32'h0);
    endtask

    initial begin
        rst_n = 0;
        ext_rst_n = 1;
        ctl_clk = 0;
        ctl_data = 0;
        ctl_latch = 1;
        tick(5);
        rst_n = 1;
        tick(1);
        t_reset();
        t_lockout();
        t_reg01();
        t_reg2();
        t_reg3();
        t_reserved();
        t_length();
        t_ext_rst();
        t_same_cycle();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule